// File: doc/BRIEF.md
# Prefetch Pipe Fault-Rerun Tracker

This block holds the two words of an instruction prefetch pipe, stage C (the older word) and stage B (the word behind it). It fills them through a simple bus request interface. It hands them to a decode consumer, and it keeps per-stage fault state in a 16-bit status word. A prefetch that ends in a bus error does not trap at once. The stage is only marked invalid and flagged for a later rerun. The exception is raised only when the consumer actually reaches for that stage. At that point the stage's "used while faulted" bit is recorded as well.

For exception return, a restore port loads both stage words, the status word, the program address of stage C and the saved supervisor bit. A return strobe then decides, for each stage, whether to rerun its prefetch, to fetch it only if it is still needed, or to accept the restored word as it is. Reruns run one at a time, stage C first. A ready output tells the surrounding logic when every required rerun has finished.

Top module: `pf_pipe_tracker`

## Requirements
- R1: After reset the status word reads 0, ready is 1, no bus request is raised, and both stages are invalid, so a consumer access gives neither use_ok nor berr_exc.
- R2: Status word bits: 15 = used-while-faulted for C, 14 = used-while-faulted for B, 13 = rerun for C, 12 = rerun for B. Bits 11..9 and bit 3 always read 0. Bits 8..4 and 2..0 return the values last loaded through the restore port.
- R3: A normal prefetch (fetch_sel 1 = C, 0 = B) that is acknowledged loads the word and makes the stage valid. One that ends with pf_berr leaves the stage invalid, sets its rerun bit and does not set its fault bit.
- R4: A consumer access to a valid stage gives use_ok and the stage word in the same cycle. An access to an invalid stage whose rerun bit is set, with no fetch pending for it, gives berr_exc in that cycle and sets that stage's fault bit on the next clock.
- R5: A fault bit is never 1 while its rerun bit is 0. A restored status word with fault set and rerun clear comes out with rerun set.
- R6: On the return strobe, a stage with rerun and fault both set gets its prefetch rerun without any other condition. Stage C uses the restored address and stage B uses that address plus 2.
- R7: On the return strobe, a stage with rerun set and fault clear gets a prefetch only if its need input (need_c, need_b) is 1. Otherwise it stays invalid with its rerun bit still set, and no bus cycle is issued for it.
- R8: On the return strobe, a stage with rerun clear takes its restored word as valid, and no bus cycle is issued for it.
- R9: A rerun uses function code 110 when the restored supervisor bit is 1 and 010 when it is 0. A normal prefetch takes its code from cur_super in the same way.
- R10: When both stages need a rerun, the stage C request comes first. Each request holds its address and code until pf_ack or pf_berr, and the next one starts only after that.
- R11: A rerun that ends in a bus error leaves the stage invalid, with its rerun bit set and its fault bit clear. A successful rerun loads the word, makes the stage valid and clears both bits of that stage.
- R12: ready is 0 from the clock after an accepted return strobe until the last required rerun completes. A return strobe while reruns are pending or in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Start a normal prefetch (taken when idle) |
| fetch_sel | input | 1 | Target stage of the prefetch: 1 = C, 0 = B |
| fetch_addr | input | ADDR_W | Address of the normal prefetch |
| cur_super | input | 1 | Current privilege for a normal prefetch |
| pf_req | output | 1 | Bus request active |
| pf_addr | output | ADDR_W | Bus address |
| pf_fc | output | 3 | Bus function code |
| pf_ack | input | 1 | Bus cycle completed with data |
| pf_berr | input | 1 | Bus cycle ended with a bus error |
| pf_data | input | WORD_W | Fetched word |
| use_req | input | 1 | Consumer reads a stage |
| use_sel | input | 1 | Stage read: 1 = C, 0 = B |
| use_ok | output | 1 | Word valid this cycle |
| use_word | output | WORD_W | Word of the selected stage |
| berr_exc | output | 1 | Bus-error exception for a faulted stage |
| ld_frame | input | 1 | Load the saved frame (taken when idle) |
| ld_ssw | input | 16 | Saved status word |
| ld_word_b | input | WORD_W | Saved stage B word |
| ld_word_c | input | WORD_W | Saved stage C word |
| ld_pc | input | ADDR_W | Program address of stage C |
| ld_super | input | 1 | Saved supervisor bit |
| rte | input | 1 | Return-from-exception strobe |
| need_b | input | 1 | Stage B word still required |
| need_c | input | 1 | Stage C word still required |
| ssw | output | 16 | Status word |
| ready | output | 1 | No rerun outstanding |

## Verification
The bench builds the block with ADDR_W set to 24. This keeps the address compare short while the plus-2 address of stage B is still checked across a real carry-free width. WORD_W stays at 16 because the status word layout fixes it. With these values the bench reaches every rerun decision path: both stages faulted, rerun only when needed, restored words trusted, a rerun that fails again, and a return strobe dropped while a rerun is still in flight.

// File: rtl/pf_pipe_tracker.sv
module pf_pipe_tracker #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic              fetch_sel,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              cur_super,
  output logic              pf_req,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [2:0]        pf_fc,
  input  logic              pf_ack,
  input  logic              pf_berr,
  input  logic [WORD_W-1:0] pf_data,
  input  logic              use_req,
  input  logic              use_sel,
  output logic              use_ok,
  output logic [WORD_W-1:0] use_word,
  output logic              berr_exc,
  input  logic              ld_frame,
  input  logic [15:0]       ld_ssw,
  input  logic [WORD_W-1:0] ld_word_b,
  input  logic [WORD_W-1:0] ld_word_c,
  input  logic [ADDR_W-1:0] ld_pc,
  input  logic              ld_super,
  input  logic              rte,
  input  logic              need_b,
  input  logic              need_c,
  output logic [15:0]       ssw,
  output logic              ready
);
  localparam logic [2:0] FC_SUP_PROG = 3'b110;
  localparam logic [2:0] FC_USR_PROG = 3'b010;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  // index 1 = stage C, index 0 = stage B
  logic [1:0]        vld, rr, ff, pend;
  logic [WORD_W-1:0] wd [2];
  logic [ADDR_W-1:0] ad [2];
  logic              busy, bsel, brerun, sup;
  logic [2:0]        bfc;
  logic [8:0]        lo;

  logic       done, can_take, issue_sel;
  logic [1:0] inflight, need, rr_ld;

  assign need      = {need_c, need_b};
  assign done      = busy & (pf_ack | pf_berr);
  assign can_take  = ~busy & ~(|pend);
  assign issue_sel = pend[1];
  assign inflight  = pend | ({2{busy}} & {bsel, ~bsel});
  assign rr_ld     = ld_ssw[13:12] | ld_ssw[15:14];

  assign pf_req   = busy;
  assign pf_addr  = ad[bsel];
  assign pf_fc    = bfc;
  assign use_word = wd[use_sel];
  assign use_ok   = use_req & vld[use_sel];
  assign berr_exc = use_req & ~vld[use_sel] & rr[use_sel] & ~inflight[use_sel];
  assign ready    = ~(|pend) & ~(busy & brerun);
  assign ssw      = {ff[1], ff[0], rr[1], rr[0], 3'b000, lo[8:4], 1'b0, lo[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; rr <= '0; ff <= '0; pend <= '0;
      wd[0] <= '0; wd[1] <= '0; ad[0] <= '0; ad[1] <= '0;
      busy <= 1'b0; bsel <= 1'b0; brerun <= 1'b0; sup <= 1'b0;
      bfc <= '0; lo <= '0;
    end else begin
      if (done) begin
        busy <= 1'b0;
        ff[bsel] <= 1'b0;
        if (pf_berr) begin
          rr[bsel] <= 1'b1;
        end else begin
          wd[bsel]  <= pf_data;
          vld[bsel] <= 1'b1;
          rr[bsel]  <= 1'b0;
        end
      end
      if (berr_exc) ff[use_sel] <= 1'b1;
      if (!busy && (|pend)) begin
        busy            <= 1'b1;
        bsel            <= issue_sel;
        brerun          <= 1'b1;
        bfc             <= sup ? FC_SUP_PROG : FC_USR_PROG;
        pend[issue_sel] <= 1'b0;
      end else if (can_take) begin
        if (ld_frame) begin
          wd[1] <= ld_word_c;
          wd[0] <= ld_word_b;
          ad[1] <= ld_pc;
          ad[0] <= ld_pc + STEP;
          rr    <= rr_ld;
          ff    <= ld_ssw[15:14];
          vld   <= ~rr_ld;
          lo    <= ld_ssw[8:0];
          sup   <= ld_super;
        end else if (rte) begin
          for (int i = 0; i < 2; i++) begin
            if (rr[i] && (ff[i] || need[i])) pend[i] <= 1'b1;
            if (!rr[i]) vld[i] <= 1'b1;
          end
        end else if (fetch_req) begin
          busy           <= 1'b1;
          bsel           <= fetch_sel;
          brerun         <= 1'b0;
          bfc            <= cur_super ? FC_SUP_PROG : FC_USR_PROG;
          ad[fetch_sel]  <= fetch_addr;
          vld[fetch_sel] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pf_pipe_tracker_chk.sv
module pf_pipe_tracker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pf_req,
  input logic              pf_ack,
  input logic              pf_berr,
  input logic [ADDR_W-1:0] pf_addr,
  input logic [2:0]        pf_fc,
  input logic              use_sel,
  input logic              use_ok,
  input logic              berr_exc,
  input logic              ld_frame,
  input logic [15:0]       ssw,
  input logic              ready
);
  // R5
  fault_has_rerun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ssw[15] || ssw[13]) && (!ssw[14] || ssw[12]));

  // R2
  zero_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ssw[11:9] == 3'b000 && !ssw[3]);

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req && !pf_ack && !pf_berr |=> pf_req && $stable(pf_addr) && $stable(pf_fc));

  // R4
  fault_c_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    berr_exc && use_sel && !ld_frame |=> ssw[15]);

  // R4
  fault_b_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    berr_exc && !use_sel && !ld_frame |=> ssw[14]);

  // R4
  ok_or_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(use_ok && berr_exc));

  // R9
  prog_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req |-> (pf_fc == 3'b110 || pf_fc == 3'b010));

  // R12
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !pf_req);
endmodule

bind pf_pipe_tracker pf_pipe_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pf_req(pf_req), .pf_ack(pf_ack), .pf_berr(pf_berr),
  .pf_addr(pf_addr), .pf_fc(pf_fc), .use_sel(use_sel), .use_ok(use_ok),
  .berr_exc(berr_exc), .ld_frame(ld_frame), .ssw(ssw), .ready(ready)
);

// File: tb/pf_pipe_tracker_bench.sv
module pf_pipe_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int WW = 16;

  logic clk = 0, rst_n = 0;
  logic fetch_req = 0, fetch_sel = 0, cur_super = 0;
  logic [AW-1:0] fetch_addr = '0;
  logic pf_req; logic [AW-1:0] pf_addr; logic [2:0] pf_fc;
  logic pf_ack = 0, pf_berr = 0; logic [WW-1:0] pf_data = '0;
  logic use_req = 0, use_sel = 0, use_ok, berr_exc; logic [WW-1:0] use_word;
  logic ld_frame = 0, ld_super = 0; logic [15:0] ld_ssw = '0;
  logic [WW-1:0] ld_word_b = '0, ld_word_c = '0; logic [AW-1:0] ld_pc = '0;
  logic rte = 0, need_b = 0, need_c = 0;
  logic [15:0] ssw; logic ready;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_pipe_tracker #(.ADDR_W(AW), .WORD_W(WW)) u_pf_pipe_tracker (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_sel(fetch_sel),
    .fetch_addr(fetch_addr), .cur_super(cur_super), .pf_req(pf_req),
    .pf_addr(pf_addr), .pf_fc(pf_fc), .pf_ack(pf_ack), .pf_berr(pf_berr),
    .pf_data(pf_data), .use_req(use_req), .use_sel(use_sel), .use_ok(use_ok),
    .use_word(use_word), .berr_exc(berr_exc), .ld_frame(ld_frame), .ld_ssw(ld_ssw),
    .ld_word_b(ld_word_b), .ld_word_c(ld_word_c), .ld_pc(ld_pc), .ld_super(ld_super),
    .rte(rte), .need_b(need_b), .need_c(need_c), .ssw(ssw), .ready(ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic serve(input bit err, input logic [WW-1:0] d,
                       input logic [AW-1:0] ea, input logic [2:0] efc, input string tag);
    for (int n = 0; n < 20 && !pf_req; n++) @(negedge clk);
    chk({tag, " req"}, 32'(pf_req), 32'd1);
    chk({tag, " addr"}, 32'(pf_addr), 32'(ea));
    chk({tag, " fc"}, 32'(pf_fc), 32'(efc));
    pf_ack = !err; pf_berr = err; pf_data = d;
    @(negedge clk);
    pf_ack = 0; pf_berr = 0;
  endtask

  task automatic use_chk(input bit sel, input bit e_ok, input bit e_exc,
                         input logic [WW-1:0] e_word, input string tag);
    use_req = 1; use_sel = sel; #1;
    chk({tag, " use_ok"}, 32'(use_ok), 32'(e_ok));
    chk({tag, " berr_exc"}, 32'(berr_exc), 32'(e_exc));
    if (e_ok) chk({tag, " word"}, 32'(use_word), 32'(e_word));
    @(negedge clk);
    use_req = 0;
  endtask

  task automatic restore(input logic [15:0] s, input logic [WW-1:0] wb, input logic [WW-1:0] wc,
                         input logic [AW-1:0] pc, input bit sp);
    ld_frame = 1; ld_ssw = s; ld_word_b = wb; ld_word_c = wc; ld_pc = pc; ld_super = sp;
    @(negedge clk);
    ld_frame = 0;
  endtask

  task automatic do_rte(input bit nb, input bit nc);
    rte = 1; need_b = nb; need_c = nc;
    @(negedge clk);
    rte = 0; need_b = 0; need_c = 0;
  endtask

  task automatic quiet(input int cyc, input string tag);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      if (pf_req) seen++;
      @(negedge clk);
    end
    chk({tag, " no bus cycle"}, 32'(seen), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 ssw", 32'(ssw), 32'h0);
    chk("R1 ready", 32'(ready), 32'd1);
    chk("R1 pf_req", 32'(pf_req), 32'd0);
    use_chk(1'b0, 1'b0, 1'b0, '0, "R1 empty B");
  endtask

  task automatic t_fetch;
    fetch_req = 1; fetch_sel = 1; fetch_addr = 24'h000100; cur_super = 1;
    @(negedge clk); fetch_req = 0;
    serve(1'b0, 16'hAAAA, 24'h000100, 3'b110, "R3 R9 fetch C");
    fetch_req = 1; fetch_sel = 0; fetch_addr = 24'h000102; cur_super = 0;
    @(negedge clk); fetch_req = 0;
    serve(1'b1, 16'h0000, 24'h000102, 3'b010, "R3 R9 fetch B");
    chk("R3 rerun B only", 32'(ssw), 32'h1000);
    chk("R3 ready after plain fault", 32'(ready), 32'd1);
    use_chk(1'b1, 1'b1, 1'b0, 16'hAAAA, "R4 valid C");
    use_chk(1'b0, 1'b0, 1'b1, '0, "R4 faulted B");
    chk("R4 R5 fault B recorded", 32'(ssw), 32'h5000);
  endtask

  task automatic t_layout;
    restore(16'hFFFF, 16'h0, 16'h0, 24'h0, 1'b0);
    chk("R2 layout", 32'(ssw), 32'hF1F7);
    restore(16'h8000, 16'h0, 16'h0, 24'h0, 1'b0);
    chk("R5 fault forces rerun", 32'(ssw), 32'hA000);
  endtask

  task automatic t_rte_both;
    restore(16'hF000, 16'h0, 16'h0, 24'h002000, 1'b1);
    do_rte(1'b0, 1'b0);
    chk("R12 ready low", 32'(ready), 32'd0);
    serve(1'b0, 16'h1111, 24'h002000, 3'b110, "R6 R10 C first");
    chk("R12 ready low between", 32'(ready), 32'd0);
    serve(1'b0, 16'h2222, 24'h002002, 3'b110, "R6 R10 B second");
    chk("R11 bits cleared", 32'(ssw), 32'h0);
    chk("R12 ready back", 32'(ready), 32'd1);
    use_chk(1'b1, 1'b1, 1'b0, 16'h1111, "R11 C word");
    use_chk(1'b0, 1'b1, 1'b0, 16'h2222, "R11 B word");
  endtask

  task automatic t_rte_need;
    restore(16'h3000, 16'hB0B0, 16'hC0C0, 24'h003000, 1'b0);
    do_rte(1'b1, 1'b0);
    serve(1'b0, 16'h4444, 24'h003002, 3'b010, "R7 R9 B needed");
    quiet(6, "R7 C not needed");
    chk("R7 C rerun kept", 32'(ssw), 32'h2000);
    chk("R7 ready", 32'(ready), 32'd1);
    use_chk(1'b0, 1'b1, 1'b0, 16'h4444, "R7 B word");
    use_chk(1'b1, 1'b0, 1'b1, '0, "R7 C invalid");
  endtask

  task automatic t_rte_clear;
    restore(16'h0000, 16'h5555, 16'h6666, 24'h004000, 1'b1);
    do_rte(1'b1, 1'b1);
    chk("R8 ready", 32'(ready), 32'd1);
    quiet(6, "R8");
    use_chk(1'b0, 1'b1, 1'b0, 16'h5555, "R8 B restored");
    use_chk(1'b1, 1'b1, 1'b0, 16'h6666, "R8 C restored");
  endtask

  task automatic t_rerun_err;
    restore(16'hF000, 16'h0, 16'h0, 24'h005000, 1'b1);
    do_rte(1'b0, 1'b0);
    serve(1'b1, 16'h0, 24'h005000, 3'b110, "R11 C fails");
    chk("R11 C rerun again", 32'(ssw), 32'h7000);
    do_rte(1'b1, 1'b1);
    chk("R12 ready low in flight", 32'(ready), 32'd0);
    rte = 1; need_c = 1; #1;
    serve(1'b0, 16'h7777, 24'h005002, 3'b110, "R11 B ok");
    rte = 0; need_c = 0;
    quiet(6, "R12 strobe ignored");
    chk("R11 final bits", 32'(ssw), 32'h2000);
    chk("R12 ready end", 32'(ready), 32'd1);
    use_chk(1'b0, 1'b1, 1'b0, 16'h7777, "R11 B word");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fetch();
    t_layout();
    t_rte_both();
    t_rte_need();
    t_rte_clear();
    t_rerun_err();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule